// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit chooses the address of the next instruction. Each cycle it takes the address of the current instruction, its 32-bit instruction word and the two source register values. It decides whether a conditional branch is taken and builds the branch or jump destination. The result goes through one register stage. Downstream fetch logic then has a stable next address, a taken flag and a flag for a malformed compare-to-zero encoding.

Two kinds of conditional branch are decoded. The first kind compares two registers for equality or inequality. The second kind tests the first register as a signed value against zero. Two of the zero tests share one opcode and are told apart by the second register field. A taken branch moves relative to the current instruction by a signed word offset. An unconditional jump keeps the top address nibble of the current PC and replaces the lower 28 bits.

Instruction fields: opcode in bits 31:26, second register field in bits 20:16, branch offset in bits 15:0, jump index in bits 25:0.

Top module: `branch_target_unit`

## Requirements
- R1: While `rstN` is low, `nextPc`, `branchTaken` and `badBranch` are all zero.
- R2: Outputs are registered. Inputs applied before a rising edge appear on the outputs after that edge, and do not appear before it.
- R3: Opcode 4 is taken when `rsVal` equals `rtVal`. Opcode 5 is taken when the two values differ.
- R4: Opcode 6 is taken when `rsVal` is at or below zero as a signed value. Opcode 7 is taken when `rsVal` is above zero. `rtVal` has no effect on either.
- R5: For opcode 1, a second register field (bits 20:16) of 0 means taken when `rsVal` is negative. A field of 1 means taken when `rsVal` is zero or positive. `rtVal` has no effect.
- R6: A taken branch gives `nextPc` = PC + 4 + 4 × sign-extended bits 15:0, with `branchTaken` = 1. For example, PC 8 with offset 2 gives 20, and PC 16 with offset -4 gives 4.
- R7: A branch that is not taken, and any opcode other than 1, 2, 4, 5, 6 or 7, gives `nextPc` = PC + 4 with `branchTaken` = 0. The sum wraps modulo 2^32.
- R8: Opcode 2 gives `nextPc` = {PC[31:28], bits 25:0, 2'b00}, with `branchTaken` = 1.
- R9: Opcode 1 with a second register field other than 0 or 1 is not taken, gives PC + 4 and sets `badBranch`. In every other case `badBranch` is 0.
- R10: The extreme offsets reach PC + 4 + 0x1FFFC (offset 0x7FFF) and PC + 4 - 0x20000 (offset 0x8000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcIn | input | 32 | Address of the current instruction |
| instrIn | input | 32 | Current instruction word |
| rsVal | input | 32 | Value of the first source register |
| rtVal | input | 32 | Value of the second source register |
| nextPc | output | 32 | Registered next instruction address |
| branchTaken | output | 1 | Registered flag: branch taken or jump |
| badBranch | output | 1 | Registered flag: opcode 1 with an undefined selector |

## Verification
The case hardest to reach from the ports is one where the second register field and the second register value disagree. Opcode 1 picks its test from the field bits inside the instruction word, while `rtVal` is a separate port that must have no effect. The bench therefore drives compare-to-zero branches with a deliberately unequal, nonzero `rtVal`, and it also drives undefined selector values. It does this with a negative `rsVal` that would make the branch taken if the selector were read as valid. The signed boundary at 0x80000000 and the two extreme offsets are driven directly.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int OPC_W   = 6;
  localparam int OPC_LSB = 26;
  localparam int RSEL_W  = 5;
  localparam int RSEL_LSB = 16;
  localparam int OFF_W   = 16;
  localparam int JIDX_W  = 26;

  localparam logic [OPC_W-1:0] OP_ZCMP = 6'd1;
  localparam logic [OPC_W-1:0] OP_JMP  = 6'd2;
  localparam logic [OPC_W-1:0] OP_EQ   = 6'd4;
  localparam logic [OPC_W-1:0] OP_NE   = 6'd5;
  localparam logic [OPC_W-1:0] OP_LEZ  = 6'd6;
  localparam logic [OPC_W-1:0] OP_GTZ  = 6'd7;

  localparam logic [RSEL_W-1:0] SEL_LTZ = 5'd0;
  localparam logic [RSEL_W-1:0] SEL_GEZ = 5'd1;

  typedef enum logic [2:0] {
    COND_NONE,
    COND_EQ,
    COND_NE,
    COND_LEZ,
    COND_GTZ,
    COND_LTZ,
    COND_GEZ
  } condE;

  typedef struct packed {
    condE cond;
    logic jump;
    logic illegal;
  } strobeT;

endpackage

// File: rtl/bru_ctrl.sv
module bru_ctrl
  import bru_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [RSEL_W-1:0] rtField,
  output strobeT            strobes
);

  always_comb begin
    strobes = '{cond: COND_NONE, jump: 1'b0, illegal: 1'b0};
    unique case (opcode)
      OP_JMP:  strobes.jump = 1'b1;
      OP_EQ:   strobes.cond = COND_EQ;
      OP_NE:   strobes.cond = COND_NE;
      OP_LEZ:  strobes.cond = COND_LEZ;
      OP_GTZ:  strobes.cond = COND_GTZ;
      OP_ZCMP: begin
        if (rtField == SEL_LTZ)      strobes.cond = COND_LTZ;
        else if (rtField == SEL_GEZ) strobes.cond = COND_GEZ;
        else                         strobes.illegal = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bru_dp.sv
module bru_dp
  import bru_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   pc,
  input  logic [JIDX_W-1:0] jumpIdx,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  strobeT            strobes,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              illegal
);

  localparam int WORD_SH  = 2;
  localparam int EXT_W    = PC_W - OFF_W - WORD_SH;
  localparam int REGION_W = PC_W - JIDX_W - WORD_SH;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [OFF_W-1:0] offset;
  logic [PC_W-1:0]  seqPc;
  logic [PC_W-1:0]  byteOffset;
  logic [PC_W-1:0]  branchPc;
  logic [PC_W-1:0]  jumpPc;
  logic             rsNeg;
  logic             rsZero;
  logic             rsEqRt;
  logic             condMet;
  logic [PC_W-1:0]  pcSel;
  logic             takeSel;

  assign offset     = jumpIdx[OFF_W-1:0];
  assign seqPc      = pc + STEP;
  assign byteOffset = {{EXT_W{offset[OFF_W-1]}}, offset, {WORD_SH{1'b0}}};
  assign branchPc   = seqPc + byteOffset;
  assign jumpPc     = {pc[PC_W-1 -: REGION_W], jumpIdx, {WORD_SH{1'b0}}};

  assign rsNeg  = rsVal[DATA_W-1];
  assign rsZero = (rsVal == '0);
  assign rsEqRt = (rsVal == rtVal);

  always_comb begin
    unique case (strobes.cond)
      COND_EQ:  condMet = rsEqRt;
      COND_NE:  condMet = !rsEqRt;
      COND_LEZ: condMet = rsNeg || rsZero;
      COND_GTZ: condMet = !rsNeg && !rsZero;
      COND_LTZ: condMet = rsNeg;
      COND_GEZ: condMet = !rsNeg;
      default:  condMet = 1'b0;
    endcase
  end

  always_comb begin
    if (strobes.jump) begin
      pcSel   = jumpPc;
      takeSel = 1'b1;
    end else if (condMet) begin
      pcSel   = branchPc;
      takeSel = 1'b1;
    end else begin
      pcSel   = seqPc;
      takeSel = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc  <= '0;
      taken   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      nextPc  <= pcSel;
      taken   <= takeSel;
      illegal <= strobes.illegal;
    end
  end

endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import bru_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [31:0]       instrIn,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  output logic [PC_W-1:0]   nextPc,
  output logic              branchTaken,
  output logic              badBranch
);

  strobeT strobes;

  bru_ctrl i_ctrl (
    .opcode  (instrIn[OPC_LSB +: OPC_W]),
    .rtField (instrIn[RSEL_LSB +: RSEL_W]),
    .strobes (strobes)
  );

  bru_dp #(.PC_W(PC_W), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pc      (pcIn),
    .jumpIdx (instrIn[JIDX_W-1:0]),
    .rsVal   (rsVal),
    .rtVal   (rtVal),
    .strobes (strobes),
    .nextPc  (nextPc),
    .taken   (branchTaken),
    .illegal (badBranch)
  );

endmodule

// File: rtl/bru_chk.sv
module bru_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] pcIn,
  input logic [31:0] instrIn,
  input logic [31:0] rsVal,
  input logic [31:0] rtVal,
  input logic [31:0] nextPc,
  input logic        branchTaken,
  input logic        badBranch
);

  // R7: a not-taken result is always the sequential address
  a_r7_seq_when_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !branchTaken) |-> nextPc == $past(pcIn) + 32'd4);

  // R9: the malformed-selector flag never accompanies a taken result
  a_r9_bad_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    badBranch |-> !branchTaken);

  // R8: jumps keep the region nibble and are always taken
  a_r8_jump_region: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(instrIn[31:26]) == 6'd2) |->
      (branchTaken && nextPc[31:28] == $past(pcIn[31:28])
       && nextPc[27:2] == $past(instrIn[25:0])));

  // R6: any taken target keeps the word alignment of the source PC
  a_r6_aligned_target: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> nextPc[1:0] == $past(pcIn[1:0]));

  // R3: equality branch outcome follows the operand comparison
  a_r3_eq_outcome: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(instrIn[31:26]) == 6'd4) |->
      branchTaken == ($past(rsVal) == $past(rtVal)));

endmodule

bind branch_target_unit bru_chk i_chk (.*);

// File: tb/test_branch_target_unit.sv
module test_branch_target_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pcIn = '0;
  logic [31:0] instrIn = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] nextPc;
  logic        branchTaken;
  logic        badBranch;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_target_unit i_branch_target_unit (.*);

  function automatic logic [31:0] mkI(input logic [5:0] op, input logic [4:0] sel,
                                      input logic [15:0] off);
    return {op, 5'd3, sel, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic [31:0] ins,
                      input logic [31:0] rs, input logic [31:0] rt);
    @(negedge clk);
    pcIn = pc; instrIn = ins; rsVal = rs; rtVal = rt;
    @(posedge clk);
    #1;
  endtask

  task automatic expect3(input string req, input logic [31:0] pc, input logic tk,
                         input logic bad);
    chk(req, nextPc, pc);
    chk(req, {31'd0, branchTaken}, {31'd0, tk});
    chk(req, {31'd0, badBranch}, {31'd0, bad});
  endtask

  task automatic t_reset();
    #1;
    expect3("R1", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    pcIn = 32'h100; instrIn = mkI(6'd2, 5'd0, 16'h1);
    @(posedge clk); #1;
    expect3("R1", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_latency();
    step(32'h200, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    pcIn = 32'h300;
    #1;
    chk("R2", nextPc, 32'h204);
    @(posedge clk); #1;
    chk("R2", nextPc, 32'h304);
  endtask

  task automatic t_examples();
    step(32'd8, mkI(6'd4, 5'd0, 16'd2), 32'd7, 32'd7);
    expect3("R6", 32'd20, 1'b1, 1'b0);
    step(32'd16, mkI(6'd5, 5'd0, 16'hFFFC), 32'd1, 32'd2);
    expect3("R6", 32'd4, 1'b1, 1'b0);
  endtask

  task automatic t_eq_ne();
    step(32'd8, mkI(6'd4, 5'd0, 16'd2), 32'd7, 32'd9);
    expect3("R3", 32'd12, 1'b0, 1'b0);
    step(32'd40, mkI(6'd5, 5'd0, 16'd2), 32'hAA, 32'hAA);
    expect3("R3", 32'd44, 1'b0, 1'b0);
  endtask

  task automatic t_lez_gtz();
    step(32'h1000, mkI(6'd6, 5'd0, 16'd1), 32'd0, 32'd5);
    expect3("R4", 32'h1008, 1'b1, 1'b0);
    step(32'h1000, mkI(6'd6, 5'd0, 16'd1), 32'hFFFF_FFFF, 32'd0);
    expect3("R4", 32'h1008, 1'b1, 1'b0);
    step(32'h1000, mkI(6'd6, 5'd0, 16'd1), 32'd1, 32'd1);
    expect3("R4", 32'h1004, 1'b0, 1'b0);
    step(32'h1000, mkI(6'd7, 5'd0, 16'd1), 32'd1, 32'd0);
    expect3("R4", 32'h1008, 1'b1, 1'b0);
    step(32'h1000, mkI(6'd7, 5'd0, 16'd1), 32'h8000_0000, 32'd9);
    expect3("R4", 32'h1004, 1'b0, 1'b0);
    step(32'h1000, mkI(6'd7, 5'd0, 16'd1), 32'd0, 32'd5);
    expect3("R4", 32'h1004, 1'b0, 1'b0);
  endtask

  task automatic t_zcmp();
    step(32'h2000, mkI(6'd1, 5'd0, 16'd3), 32'hFFFF_FFFB, 32'd0);
    expect3("R5", 32'h2010, 1'b1, 1'b0);
    step(32'h2000, mkI(6'd1, 5'd0, 16'd3), 32'd0, 32'hFFFF_FFFF);
    expect3("R5", 32'h2004, 1'b0, 1'b0);
    step(32'h2000, mkI(6'd1, 5'd1, 16'd3), 32'd0, 32'h1234);
    expect3("R5", 32'h2010, 1'b1, 1'b0);
    step(32'h2000, mkI(6'd1, 5'd1, 16'd3), 32'hFFFF_FFFF, 32'd7);
    expect3("R5", 32'h2004, 1'b0, 1'b0);
  endtask

  task automatic t_bad_sel();
    step(32'h3000, mkI(6'd1, 5'd2, 16'd3), 32'hFFFF_FFFF, 32'd2);
    expect3("R9", 32'h3004, 1'b0, 1'b1);
    step(32'h3000, mkI(6'd1, 5'd31, 16'd3), 32'd5, 32'd31);
    expect3("R9", 32'h3004, 1'b0, 1'b1);
  endtask

  task automatic t_jump();
    step(32'hA000_0010, {6'd2, 26'h0123456}, 32'd0, 32'd0);
    expect3("R8", 32'hA048_D158, 1'b1, 1'b0);
    step(32'h5FFF_FFFC, {6'd2, 26'h3FFFFFF}, 32'd1, 32'd2);
    expect3("R8", 32'h5FFF_FFFC, 1'b1, 1'b0);
  endtask

  task automatic t_seq();
    step(32'h4000, 32'h0234_4020, 32'd1, 32'd1);
    expect3("R7", 32'h4004, 1'b0, 1'b0);
    step(32'hFFFF_FFFC, 32'h2000_0001, 32'd0, 32'd0);
    expect3("R7", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_reach();
    step(32'h1000, mkI(6'd4, 5'd0, 16'h7FFF), 32'd0, 32'd0);
    expect3("R10", 32'h0002_1000, 1'b1, 1'b0);
    step(32'h0004_0000, mkI(6'd4, 5'd0, 16'h8000), 32'd0, 32'd0);
    expect3("R10", 32'h0002_0004, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_examples();
    t_eq_ne();
    t_lez_gtz();
    t_zcmp();
    t_bad_sel();
    t_jump();
    t_seq();
    t_reach();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule